// File: doc/BRIEF.md
# NAND Tree Test Controller

This block sits between the functional core and the pad ring of a chip with many I/O pins. It decides whether the pads carry normal traffic or serve one of two manufacturing test modes. The mode comes from an active-low test-enable pin and three interrupt-request pins that are borrowed as mode selectors. The decode is purely combinational, so the selecting pins must be held steady for the whole test.

In tri-state mode every pad driver is switched off. In NAND tree mode every chain pad has its driver switched off and feeds a NAND chain. Two observation pads stay driven. One shows an intermediate tap of the chain, and the other shows the final chain output. The chain visits the pads in a fixed counter-clockwise order. Some chain inputs are inverted before they enter the chain. The stimulus that sets every node to a known level therefore drives those pads to 0 and all other pads to 1. From that state, flipping any single chain pad changes the final output.

Pads are modelled as vectors. Pads 0 to NCHAIN-1 are chain pads. Pad NCHAIN is the intermediate observation pad, and pad NCHAIN+1 is the final observation pad. The clock and the test-enable pin are separate ports and are not part of the chain.

Top module: `nand_tree_ctl`

## Requirements
- R1: While `test_en_n` is 1, all three select pins are ignored. `pad_oe` equals `func_oe` and `pad_out` equals `func_out` on every pad.
- R2: With `test_en_n` at 0 and `irq5_sel` at 1, NAND tree mode is selected. This holds for every value of `irq7_sel` and `irq6_sel`.
- R3: With `test_en_n` at 0 and both `irq7_sel` and `irq5_sel` at 0, NAND tree mode is also selected, for either value of `irq6_sel`.
- R4: With `test_en_n` at 0 and the selects {irq7, irq6, irq5} at 3'b110, tri-state mode is selected. Every bit of `pad_oe` is then 0, and `pad_out` equals `func_out`.
- R5: With `test_en_n` at 0 and the selects at 3'b100, the block stays in normal mode and passes `func_oe` and `func_out` through.
- R6: In NAND tree mode, `pad_oe` is 0 on every chain pad and 1 on both observation pads. Chain pads carry `func_out` on `pad_out`.
- R7: Chain stage k reads pad index (FIRST_PAD - k) mod NCHAIN, with FIRST_PAD defaulting to 5. In NAND tree mode, the intermediate pad (index NCHAIN) outputs 1 exactly when some stage 0..MID_STAGE sees an effective input of 0. MID_STAGE defaults to 15.
- R8: The effective input of a chain pad is `pad_in` XOR its bit of INV_MASK. INV_MASK defaults to 32'hA5A5_0C15, which gives 13 inverted pads. In NAND tree mode, the final pad (index NCHAIN+1) outputs 1 exactly when some effective input is 0.
- R9: Set `pad_in` to ~INV_MASK. Both observation pads then output 0. Flipping any one chain pad from that stimulus drives the final pad to 1.
- R10: The mode decode and the chain are asynchronous. A change on the select pins or on `pad_in` reaches the pad outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the checking logic |
| rst | input | 1 | Synchronous active-high reset for the checking logic |
| test_en_n | input | 1 | Active-low test enable |
| irq7_sel | input | 1 | Borrowed select pin, most significant |
| irq6_sel | input | 1 | Borrowed select pin, middle |
| irq5_sel | input | 1 | Borrowed select pin, least significant |
| pad_in | input | NCHAIN | Levels received on the chain pads |
| func_oe | input | NCHAIN+2 | Functional output enables from the core |
| func_out | input | NCHAIN+2 | Functional output data from the core |
| pad_oe | output | NCHAIN+2 | Driver enables sent to the pads |
| pad_out | output | NCHAIN+2 | Output data sent to the pads |

## Verification
Mode selection and chain evaluation can change in the same cycle. A single change on the select pins both switches the observation pads to their drivers and places the chain result on them. The bench provokes this in two ways. It sweeps all sixteen select and enable combinations with the chain stimulus already applied. It also changes the selects in the middle of a clock period and samples before the next edge. Each sample is judged against the mode and chain values that the bench derives arithmetically from the requirements.

// File: rtl/ntc_pkg.sv
package ntc_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'd0,
        MODE_TRISTATE = 2'd1,
        MODE_NAND     = 2'd2
    } test_mode_t;

    typedef struct packed {
        logic hi;
        logic mid;
        logic lo;
    } mode_sel_t;

    localparam int unsigned DEF_NCHAIN    = 32;
    localparam int unsigned DEF_FIRST_PAD = 5;
    localparam int unsigned DEF_MID_STAGE = 15;
    localparam logic [DEF_NCHAIN-1:0] DEF_INV_MASK = 32'hA5A5_0C15;

    // NAND tree wins over tri-state when both encodings are present.
    function automatic test_mode_t decode_mode(input logic te_n, input mode_sel_t s);
        test_mode_t m;
        m = MODE_NORMAL;
        if (!te_n) begin
            if (s.lo || !s.hi)
                m = MODE_NAND;
            else if (s.hi && s.mid && !s.lo)
                m = MODE_TRISTATE;
        end
        return m;
    endfunction

    // Pad visited by a chain stage, walking downward (counter-clockwise).
    function automatic int unsigned ccw_pad(input int unsigned stage,
                                            input int unsigned first,
                                            input int unsigned n);
        return (first + n - (stage % n)) % n;
    endfunction

endpackage

// File: rtl/ntc_mode_decode.sv
module ntc_mode_decode
    import ntc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       te_n,
    input  mode_sel_t  sel,
    output test_mode_t mode
);

    assign mode = decode_mode(te_n, sel);

    AST_TESTEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        te_n |-> (mode == MODE_NORMAL)); // R1

    AST_TRI_ENCODING: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_TRISTATE) |-> (!te_n && sel.hi && sel.mid && !sel.lo)); // R4

    AST_LO_SELECTS_NAND: assert property (@(posedge clk) disable iff (rst)
        (!te_n && sel.lo) |-> (mode == MODE_NAND)); // R2

endmodule

// File: rtl/ntc_nand_chain.sv
module ntc_nand_chain
    import ntc_pkg::*;
#(
    parameter int unsigned NCHAIN    = DEF_NCHAIN,
    parameter int unsigned FIRST_PAD = DEF_FIRST_PAD,
    parameter int unsigned MID_STAGE = DEF_MID_STAGE,
    parameter logic [NCHAIN-1:0] INV_MASK = DEF_INV_MASK
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [NCHAIN-1:0] chain_in,
    output logic              mid_tap,
    output logic              final_out
);

    logic [NCHAIN-1:0] eff;

    // Each stage: NAND of the inverted previous node and its own input,
    // so every node rests at 0 under the all-ones effective stimulus.
    for (genvar k = 0; k < NCHAIN; k++) begin : g_stage
        localparam int unsigned PAD = ccw_pad(k, FIRST_PAD, NCHAIN);
        logic node;
        assign eff[k] = chain_in[PAD] ^ INV_MASK[PAD];
        if (k == 0) begin : g_head
            assign node = ~eff[k];
        end else begin : g_link
            assign node = ~(~g_stage[k-1].node & eff[k]);
        end
    end

    assign mid_tap   = g_stage[MID_STAGE].node;
    assign final_out = g_stage[NCHAIN-1].node;

    AST_MID_TO_FINAL: assert property (@(posedge clk) disable iff (rst)
        mid_tap |-> final_out); // R7

    AST_ALL_HIGH_QUIET: assert property (@(posedge clk) disable iff (rst)
        (&eff) |-> (!final_out && !mid_tap)); // R9

    AST_ANY_LOW_FINAL: assert property (@(posedge clk) disable iff (rst)
        (eff != '1) |-> final_out); // R8

endmodule

// File: rtl/ntc_pad_mux.sv
module ntc_pad_mux
    import ntc_pkg::*;
#(
    parameter int unsigned NCHAIN = DEF_NCHAIN,
    localparam int unsigned NPAD = NCHAIN + 2
)(
    input  logic            clk,
    input  logic            rst,
    input  test_mode_t      mode,
    input  logic [NPAD-1:0] func_oe,
    input  logic [NPAD-1:0] func_out,
    input  logic            mid_tap,
    input  logic            final_out,
    output logic [NPAD-1:0] pad_oe,
    output logic [NPAD-1:0] pad_out
);

    always_comb begin
        pad_oe  = func_oe;
        pad_out = func_out;
        case (mode)
            MODE_TRISTATE: begin
                pad_oe = '0;
            end
            MODE_NAND: begin
                pad_oe            = '0;
                pad_oe[NCHAIN]    = 1'b1;
                pad_oe[NCHAIN+1]  = 1'b1;
                pad_out[NCHAIN]   = mid_tap;
                pad_out[NCHAIN+1] = final_out;
            end
            default: ;
        endcase
    end

    AST_TRI_DARK: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_TRISTATE) |-> (pad_oe == '0)); // R4

    AST_NAND_OE: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_NAND) |-> (pad_oe == {2'b11, {NCHAIN{1'b0}}})); // R6

    AST_NAND_OBS: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_NAND) |-> (pad_out[NCHAIN+1] == final_out && pad_out[NCHAIN] == mid_tap)); // R8

    AST_NORMAL_THRU: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_NORMAL) |-> (pad_oe == func_oe && pad_out == func_out)); // R1

endmodule

// File: rtl/nand_tree_ctl.sv
module nand_tree_ctl
    import ntc_pkg::*;
#(
    parameter int unsigned NCHAIN    = DEF_NCHAIN,
    parameter int unsigned FIRST_PAD = DEF_FIRST_PAD,
    parameter int unsigned MID_STAGE = DEF_MID_STAGE,
    parameter logic [NCHAIN-1:0] INV_MASK = DEF_INV_MASK,
    localparam int unsigned NPAD = NCHAIN + 2
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              test_en_n,
    input  logic              irq7_sel,
    input  logic              irq6_sel,
    input  logic              irq5_sel,
    input  logic [NCHAIN-1:0] pad_in,
    input  logic [NPAD-1:0]   func_oe,
    input  logic [NPAD-1:0]   func_out,
    output logic [NPAD-1:0]   pad_oe,
    output logic [NPAD-1:0]   pad_out
);

    test_mode_t mode;
    mode_sel_t  sel;
    logic       mid_tap;
    logic       final_out;

    assign sel = '{hi: irq7_sel, mid: irq6_sel, lo: irq5_sel};

    ntc_mode_decode u_decode (
        .clk  (clk),
        .rst  (rst),
        .te_n (test_en_n),
        .sel  (sel),
        .mode (mode)
    );

    ntc_nand_chain #(
        .NCHAIN    (NCHAIN),
        .FIRST_PAD (FIRST_PAD),
        .MID_STAGE (MID_STAGE),
        .INV_MASK  (INV_MASK)
    ) u_chain (
        .clk       (clk),
        .rst       (rst),
        .chain_in  (pad_in),
        .mid_tap   (mid_tap),
        .final_out (final_out)
    );

    ntc_pad_mux #(
        .NCHAIN (NCHAIN)
    ) u_mux (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .func_oe   (func_oe),
        .func_out  (func_out),
        .mid_tap   (mid_tap),
        .final_out (final_out),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out)
    );

    AST_NAND_LOW_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (!test_en_n && !irq7_sel && !irq5_sel) |-> (pad_oe[NCHAIN+1] && !pad_oe[0])); // R3

endmodule

// File: tb/nand_tree_ctl_bench.sv
`timescale 1ns/1ps
module nand_tree_ctl_bench;

    localparam int NCH  = 32;
    localparam int NPD  = NCH + 2;
    localparam int FIRST = 5;
    localparam int MIDS = 15;
    localparam logic [NCH-1:0] INV = 32'hA5A5_0C15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic test_en_n = 1'b1;
    logic irq7_sel = 1'b0, irq6_sel = 1'b0, irq5_sel = 1'b0;
    logic [NCH-1:0] pad_in = '0;
    logic [NPD-1:0] func_oe = '0, func_out = '0;
    logic [NPD-1:0] pad_oe, pad_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nand_tree_ctl u_nand_tree_ctl (
        .clk(clk), .rst(rst), .test_en_n(test_en_n),
        .irq7_sel(irq7_sel), .irq6_sel(irq6_sel), .irq5_sel(irq5_sel),
        .pad_in(pad_in), .func_oe(func_oe), .func_out(func_out),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int stage_pad(input int k);
        return (FIRST + NCH - k) % NCH;
    endfunction

    // Expected observation values from the requirement arithmetic.
    function automatic logic exp_final(input logic [NCH-1:0] pin);
        return ((pin ^ INV) != '1);
    endfunction

    function automatic logic exp_mid(input logic [NCH-1:0] pin);
        logic r = 1'b0;
        for (int k = 0; k <= MIDS; k++)
            if (!(pin[stage_pad(k)] ^ INV[stage_pad(k)])) r = 1'b1;
        return r;
    endfunction

    task automatic set_sel(input logic te, input logic i7, input logic i6, input logic i5);
        test_en_n = te; irq7_sel = i7; irq6_sel = i6; irq5_sel = i5;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [31:0] lfsr = 32'h1ACE_B00C;
        func_oe  = 34'h2_1234_5678;
        func_out = 34'h1_9ABC_DEF0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: no test selected, pads pass the core through.
        check("R1 reset oe", 64'(pad_oe), 64'(func_oe));
        check("R1 reset out", 64'(pad_out), 64'(func_out));
        rst = 1'b0;

        // Sweep every enable/select combination with the resting chain stimulus.
        for (int c = 0; c < 16; c++) begin
            logic te, i7, i6, i5, nand_e, tri_e;
            logic [NPD-1:0] eo, eout;
            string tag;
            @(negedge clk);
            te = c[3]; i7 = c[2]; i6 = c[1]; i5 = c[0];
            func_oe  = {c[1:0], 32'hF0F0_1234 ^ (32'(c) * 32'h1111_1111)};
            func_out = {c[3:2], 32'h0F0F_A5C3 ^ (32'(c) * 32'h0101_0101)};
            pad_in   = ~INV;
            set_sel(te, i7, i6, i5);
            nand_e = !te && (i5 || !i7);
            tri_e  = !te && i7 && i6 && !i5;
            if (te)          tag = "R1";
            else if (i5)     tag = "R2";
            else if (!i7)    tag = "R3";
            else if (tri_e)  tag = "R4";
            else             tag = "R5";
            eo = func_oe; eout = func_out;
            if (nand_e) begin
                eo = {2'b11, {NCH{1'b0}}};
                eout[NCH+1:NCH] = 2'b00;
            end else if (tri_e) begin
                eo = '0;
            end
            #1;
            check({tag, " oe"}, 64'(pad_oe), 64'(eo));
            check({tag, " out"}, 64'(pad_out), 64'(eout));
        end

        // Single-pad flips in the first NAND encoding.
        @(negedge clk);
        set_sel(1'b0, 1'b1, 1'b0, 1'b1);
        pad_in = ~INV;
        #1;
        check("R9 resting obs", 64'(pad_out[NCH+1:NCH]), 64'd0);
        check("R6 nand chain out", 64'(pad_out[NCH-1:0]), 64'(func_out[NCH-1:0]));
        for (int k = 0; k < NCH; k++) begin
            @(negedge clk);
            pad_in = ~INV ^ (32'd1 << stage_pad(k));
            #1;
            check("R9 flip final", 64'(pad_out[NCH+1]), 64'd1);
            check("R7 flip mid", 64'(pad_out[NCH]), 64'(k <= MIDS));
        end

        // Sparse pseudo-random patterns under the second NAND encoding.
        @(negedge clk);
        set_sel(1'b0, 1'b0, 1'b1, 1'b0);
        for (int n = 0; n < 60; n++) begin
            logic [31:0] a, b;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b = lfsr;
            @(negedge clk);
            pad_in = (n % 5 == 0) ? ~INV : (~INV ^ (a & b & (n[0] ? 32'h0000_FFFF : 32'hFFFF_0000)));
            #1;
            check("R8 final", 64'(pad_out[NCH+1]), 64'(exp_final(pad_in)));
            check("R7 mid", 64'(pad_out[NCH]), 64'(exp_mid(pad_in)));
            check("R3 oe", 64'(pad_oe), 64'({2'b11, {NCH{1'b0}}}));
        end

        // Mid-period mode change: outputs follow with no clock edge.
        @(posedge clk);
        #2;
        func_oe = '1;
        pad_in  = ~INV ^ 32'h0000_0100;
        set_sel(1'b0, 1'b1, 1'b1, 1'b0);
        #1;
        check("R10 tri async", 64'(pad_oe), 64'd0);
        set_sel(1'b0, 1'b1, 1'b1, 1'b1);
        #1;
        check("R10 nand async", 64'(pad_out[NCH+1]), 64'd1);
        set_sel(1'b1, 1'b1, 1'b1, 1'b1);
        #1;
        check("R10 normal async", 64'(pad_oe), 64'(func_oe));

        repeat (2) @(posedge clk);
        summary();
    end

endmodule